// File: doc/BRIEF.md
# Masked Match Table with Insert Queue

This block is a small content-addressable store. Each stored word is 64 bits wide: the upper 32 bits are the pattern that lookups compare and the lower 32 bits are the result returned on a hit. A client drives one-cycle commands with a 64-bit operand. The commands insert a word, delete by pattern, look up a pattern, clear everything, load the global don't-care mask, load the almost-full threshold and choose the insert mode.

In direct mode an insert lands in the lowest free table slot. In queued mode it lands in a four-slot side queue instead. Queued words take part in lookups from the next cycle on. Each idle cycle moves one queued word into the table. In queued mode an insert whose pattern is already stored replaces that word's result and adds no second copy. The block shows the number of stored words, queue-full, table-full and almost-full at all times, and it pulses a reject flag when an insert finds no room.

Top module: `mtq_table`

## Requirements
- R1: A lookup (`cmd_op`=2) compares only pattern bits whose global mask bit is 0. One cycle after the command, `chk_done` pulses, and with it `chk_hit` and `chk_out` (the result field, or 0 on a miss).
- R2: When several words hit, a queue word wins over any table word. Within the queue or within the table, the lowest slot index wins.
- R3: In direct mode (`cmd_op`=6 with `cmd_data[0]`=0, the mode after reset), an insert (`cmd_op`=0) writes the lowest free table slot with no duplicate check, so a repeated pattern adds a second word.
- R4: In queued mode (`cmd_op`=6 with `cmd_data[0]`=1), an insert of a new pattern takes the lowest free queue slot and can be found by a lookup in the very next cycle.
- R5: In queued mode, an insert whose pattern exactly equals a stored word (in the queue or the table) replaces that word's result and leaves the count unchanged, even when the queue is full.
- R6: In a cycle with no command, one queue word (the lowest valid slot) moves to the lowest free table slot, provided one exists. The count does not change and a queue slot is freed.
- R7: A delete (`cmd_op`=1) invalidates every stored word whose pattern equals the operand on the bits whose mask bit is 0. Other words stay.
- R8: An insert that needs a queue slot while the queue is full, or a table slot in direct mode while the table is full, stores nothing. It pulses `ins_rej` one cycle later.
- R9: `a_full` is 1 while the count is at or above the threshold set by `cmd_op`=5 (`cmd_data[4:0]`). The threshold after reset is 16.
- R10: A clear (`cmd_op`=3) invalidates all table and queue words, so the count reads 0 in the next cycle.
- R11: `entry_count` gives the number of valid table and queue words. `q_full` and `t_full` show that every queue slot, or every table slot, is valid.
- R12: A mask load (`cmd_op`=4) takes `cmd_data[63:32]` as the mask, where a 1 bit means don't care. The mask is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 64 | Operand: pattern in [63:32], result in [31:0] |
| chk_done | output | 1 | Lookup finished, one-cycle pulse |
| chk_hit | output | 1 | Lookup found a word |
| chk_out | output | 32 | Result field of the winning word |
| ins_rej | output | 1 | Insert refused for lack of room |
| entry_count | output | 5 | Valid words in table plus queue |
| q_full | output | 1 | All queue slots valid |
| t_full | output | 1 | All table slots valid |
| a_full | output | 1 | Count at or above threshold |

## Verification
A wrong valid bit shows on `entry_count` in the cycle after the command that caused it. A lost or misplaced word shows at the first lookup of its pattern, which the bench issues back-to-back with inserts so that queue-resident words are still in the queue when looked up. A bad drain only becomes visible after an idle cycle: the bench then checks that the count held and that `q_full` fell. A wrong priority shows only when several words hit at once, so the bench arranges overlapping masked hits between the queue and the table and between duplicate table slots.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
  typedef enum logic [2:0] {
    OP_INSERT = 3'd0,
    OP_DELETE = 3'd1,
    OP_CHECK  = 3'd2,
    OP_CLEAR  = 3'd3,
    OP_MASK   = 3'd4,
    OP_AFULL  = 3'd5,
    OP_MODE   = 3'd6
  } mtq_op_e;
endpackage

// File: rtl/mtq_search.sv
module mtq_search #(
  parameter int N = 16,
  parameter int W = 32
) (
  input  logic [N-1:0]        vld,
  input  logic [N-1:0][W-1:0] keys,
  input  logic [W-1:0]        probe,
  input  logic [W-1:0]        care,
  output logic [N-1:0]        hit
);
  function automatic logic masked_eq(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [W-1:0] c);
    return ((a ^ b) & c) == '0;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && masked_eq(keys[g], probe, care);
  end
endmodule

// File: rtl/mtq_prio.sv
module mtq_prio #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mtq_table.sv
module mtq_table
  import mtq_pkg::*;
#(
  parameter int TBL_DEPTH = 16,
  parameter int Q_DEPTH   = 4,
  parameter int MATCH_W   = 32,
  parameter int OUT_W     = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cmd_valid,
  input  logic [2:0]                                cmd_op,
  input  logic [MATCH_W+OUT_W-1:0]                  cmd_data,
  output logic                                      chk_done,
  output logic                                      chk_hit,
  output logic [OUT_W-1:0]                          chk_out,
  output logic                                      ins_rej,
  output logic [$clog2(TBL_DEPTH+Q_DEPTH+1)-1:0]    entry_count,
  output logic                                      q_full,
  output logic                                      t_full,
  output logic                                      a_full
);
  localparam int TD  = TBL_DEPTH;
  localparam int QD  = Q_DEPTH;
  localparam int MW  = MATCH_W;
  localparam int OW  = OUT_W;
  localparam int EW  = MW + OW;
  localparam int CW  = $clog2(TD + QD + 1);
  localparam int TIW = (TD > 1) ? $clog2(TD) : 1;
  localparam int QIW = (QD > 1) ? $clog2(QD) : 1;

  function automatic logic [CW-1:0] ones(input logic [TD+QD-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < TD + QD; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  // storage
  logic [TD-1:0]         t_vld;
  logic [TD-1:0][MW-1:0] t_key;
  logic [TD-1:0][OW-1:0] t_val;
  logic [QD-1:0]         q_vld;
  logic [QD-1:0][MW-1:0] q_key;
  logic [QD-1:0][OW-1:0] q_val;
  logic                  buf_mode;
  logic [MW-1:0]         gmask;
  logic [CW-1:0]         af_pt;

  // command decode
  logic [MW-1:0] op_key;
  logic [OW-1:0] op_val;
  logic cmd_ins, cmd_del, cmd_chk, cmd_clr, cmd_msk, cmd_af, cmd_mode;
  assign op_key   = cmd_data[EW-1:OW];
  assign op_val   = cmd_data[OW-1:0];
  assign cmd_ins  = cmd_valid && (cmd_op == OP_INSERT);
  assign cmd_del  = cmd_valid && (cmd_op == OP_DELETE);
  assign cmd_chk  = cmd_valid && (cmd_op == OP_CHECK);
  assign cmd_clr  = cmd_valid && (cmd_op == OP_CLEAR);
  assign cmd_msk  = cmd_valid && (cmd_op == OP_MASK);
  assign cmd_af   = cmd_valid && (cmd_op == OP_AFULL);
  assign cmd_mode = cmd_valid && (cmd_op == OP_MODE);

  // searches: masked for lookup/delete, exact for duplicate detection
  logic [TD-1:0] t_mhit, t_dhit;
  logic [QD-1:0] q_mhit, q_dhit;
  mtq_search #(.N(TD), .W(MW)) i_t_mask (.vld(t_vld), .keys(t_key), .probe(op_key),
                                         .care(~gmask), .hit(t_mhit));
  mtq_search #(.N(QD), .W(MW)) i_q_mask (.vld(q_vld), .keys(q_key), .probe(op_key),
                                         .care(~gmask), .hit(q_mhit));
  mtq_search #(.N(TD), .W(MW)) i_t_dup  (.vld(t_vld), .keys(t_key), .probe(op_key),
                                         .care({MW{1'b1}}), .hit(t_dhit));
  mtq_search #(.N(QD), .W(MW)) i_q_dup  (.vld(q_vld), .keys(q_key), .probe(op_key),
                                         .care({MW{1'b1}}), .hit(q_dhit));

  // priority picks
  logic tm_any, qm_any, tf_any, qf_any, qo_any, td_any, qd_any;
  logic [TIW-1:0] tm_idx, tf_idx, td_idx;
  logic [QIW-1:0] qm_idx, qf_idx, qo_idx, qd_idx;
  mtq_prio #(.N(TD), .IW(TIW)) i_p_tm (.req(t_mhit), .any(tm_any), .idx(tm_idx));
  mtq_prio #(.N(QD), .IW(QIW)) i_p_qm (.req(q_mhit), .any(qm_any), .idx(qm_idx));
  mtq_prio #(.N(TD), .IW(TIW)) i_p_tf (.req(~t_vld), .any(tf_any), .idx(tf_idx));
  mtq_prio #(.N(QD), .IW(QIW)) i_p_qf (.req(~q_vld), .any(qf_any), .idx(qf_idx));
  mtq_prio #(.N(QD), .IW(QIW)) i_p_qo (.req(q_vld),  .any(qo_any), .idx(qo_idx));
  mtq_prio #(.N(TD), .IW(TIW)) i_p_td (.req(t_dhit), .any(td_any), .idx(td_idx));
  mtq_prio #(.N(QD), .IW(QIW)) i_p_qd (.req(q_dhit), .any(qd_any), .idx(qd_idx));

  // named internal events
  logic ev_dup_q, ev_dup_t, ev_buf_new, ev_q_push, ev_fast, ev_t_push, ev_rej, ev_drain;
  assign ev_dup_q   = cmd_ins && buf_mode && qd_any;
  assign ev_dup_t   = cmd_ins && buf_mode && !qd_any && td_any;
  assign ev_buf_new = cmd_ins && buf_mode && !qd_any && !td_any;
  assign ev_q_push  = ev_buf_new && qf_any;
  assign ev_fast    = cmd_ins && !buf_mode;
  assign ev_t_push  = ev_fast && tf_any;
  assign ev_rej     = (ev_buf_new && !qf_any) || (ev_fast && !tf_any);
  assign ev_drain   = !cmd_valid && qo_any && tf_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_vld    <= '0;
      t_key    <= '0;
      t_val    <= '0;
      q_vld    <= '0;
      q_key    <= '0;
      q_val    <= '0;
      buf_mode <= 1'b0;
      gmask    <= '0;
      af_pt    <= CW'(TD);
      chk_done <= 1'b0;
      chk_hit  <= 1'b0;
      chk_out  <= '0;
      ins_rej  <= 1'b0;
    end else begin
      chk_done <= cmd_chk;
      chk_hit  <= cmd_chk && (qm_any || tm_any);
      chk_out  <= !cmd_chk ? '0 : qm_any ? q_val[qm_idx] : tm_any ? t_val[tm_idx] : '0;
      ins_rej  <= ev_rej;
      if (cmd_clr) begin
        t_vld <= '0;
        q_vld <= '0;
      end
      if (cmd_del) begin
        t_vld <= t_vld & ~t_mhit;
        q_vld <= q_vld & ~q_mhit;
      end
      if (ev_t_push) begin
        t_vld[tf_idx] <= 1'b1;
        t_key[tf_idx] <= op_key;
        t_val[tf_idx] <= op_val;
      end
      if (ev_q_push) begin
        q_vld[qf_idx] <= 1'b1;
        q_key[qf_idx] <= op_key;
        q_val[qf_idx] <= op_val;
      end
      if (ev_dup_q) q_val[qd_idx] <= op_val;
      if (ev_dup_t) t_val[td_idx] <= op_val;
      if (ev_drain) begin
        q_vld[qo_idx] <= 1'b0;
        t_vld[tf_idx] <= 1'b1;
        t_key[tf_idx] <= q_key[qo_idx];
        t_val[tf_idx] <= q_val[qo_idx];
      end
      if (cmd_msk)  gmask    <= op_key;
      if (cmd_af)   af_pt    <= cmd_data[CW-1:0];
      if (cmd_mode) buf_mode <= cmd_data[0];
    end
  end

  assign entry_count = ones({q_vld, t_vld});
  assign q_full      = &q_vld;
  assign t_full      = &t_vld;
  assign a_full      = entry_count >= af_pt;

  // assertions
  AST_DONE_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> $past(cmd_chk));                                           // R1
  AST_HIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit |-> chk_done);                                                  // R1
  AST_DIRECT_SKIPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fast |=> $stable(q_vld));                                            // R3
  AST_DUP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dup_q || ev_dup_t) |=> $stable(entry_count));                       // R5
  AST_DRAIN_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drain |=> $stable(entry_count));                                     // R6
  AST_REJ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rej |=> ($stable(t_vld) && $stable(q_vld) && ins_rej));              // R8
  AST_QFULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ins && buf_mode && q_full && !qd_any && !td_any) |=> ins_rej);     // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (entry_count == '0));                                       // R10
endmodule

// File: tb/test_mtq_table.sv
`timescale 1ns/1ps
module test_mtq_table;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [63:0] cmd_data;
  logic        chk_done, chk_hit, ins_rej, q_full, t_full, a_full;
  logic [31:0] chk_out;
  logic [4:0]  entry_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [32:0] sb_exp[$];
  string       sb_tag[$];

  mtq_table i_mtq_table (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .chk_done(chk_done), .chk_hit(chk_hit), .chk_out(chk_out), .ins_rej(ins_rej),
    .entry_count(entry_count), .q_full(q_full), .t_full(t_full), .a_full(a_full));

  always #2.5 clk = ~clk;

  task automatic expect_eq(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [63:0] d);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ins(input logic [31:0] k, input logic [31:0] v);
    issue(3'd0, {k, v});
  endtask

  task automatic lookup(input logic [31:0] k, input logic hit, input logic [31:0] v,
                        input string tag);
    sb_exp.push_back({hit, v});
    sb_tag.push_back(tag);
    issue(3'd2, {k, 32'h0});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected lookup results as they appear
  always @(negedge clk) begin
    if (rst_n && chk_done) begin
      if (sb_exp.size() == 0) begin
        expect_eq("R1 unexpected done", 33'h1, 33'h0);
      end else begin
        logic [32:0] e;
        string t;
        e = sb_exp.pop_front();
        t = sb_tag.pop_front();
        expect_eq(t, {chk_hit, chk_out}, e);
      end
    end
  end

  initial begin
    #900000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    cmd_data = '0;
    idle(3);
    expect_eq("R11 reset count", 33'(entry_count), 33'd0);
    expect_eq("R11 reset flags", 33'({q_full, t_full, a_full, chk_done, ins_rej}), 33'd0);
    rst_n = 1'b1;
    idle(2);

    // direct mode
    ins(32'h100, 32'hA000);
    ins(32'h101, 32'hA001);
    ins(32'h102, 32'hA002);
    expect_eq("R3 direct count", 33'(entry_count), 33'd3);
    lookup(32'h101, 1'b1, 32'hA001, "R1 exact hit");
    lookup(32'h555, 1'b0, 32'h0, "R1 miss");
    issue(3'd4, {32'h0000_000F, 32'h0});
    lookup(32'h10F, 1'b1, 32'hA000, "R2 R12 masked lowest slot");
    issue(3'd4, 64'h0);
    ins(32'h100, 32'hB000);
    expect_eq("R3 duplicate kept", 33'(entry_count), 33'd4);
    lookup(32'h100, 1'b1, 32'hA000, "R3 R2 first copy wins");

    // queued mode, back-to-back so nothing drains
    issue(3'd6, 64'h1);
    ins(32'h200, 32'hC000);
    expect_eq("R4 queued count", 33'(entry_count), 33'd5);
    lookup(32'h200, 1'b1, 32'hC000, "R4 queued visible");
    ins(32'h103, 32'hD003);
    issue(3'd4, {32'h0000_000F, 32'h0});
    lookup(32'h100, 1'b1, 32'hD003, "R2 queue over table");

    idle(3);
    expect_eq("R6 drain count", 33'(entry_count), 33'd6);
    expect_eq("R6 queue freed", 33'(q_full), 33'd0);
    issue(3'd4, 64'h0);
    ins(32'h200, 32'hEEEE);
    expect_eq("R5 overwrite count", 33'(entry_count), 33'd6);
    lookup(32'h200, 1'b1, 32'hEEEE, "R5 overwrite value");

    for (int i = 0; i < 4; i++) ins(32'h300 + i, 32'hF000 + i);
    expect_eq("R11 queue full", 33'(q_full), 33'd1);
    expect_eq("R11 count ten", 33'(entry_count), 33'd10);
    ins(32'h304, 32'hF004);
    expect_eq("R8 queue reject", 33'(ins_rej), 33'd1);
    expect_eq("R8 count held", 33'(entry_count), 33'd10);
    ins(32'h301, 32'h1234);
    expect_eq("R5 dup when full no reject", 33'(ins_rej), 33'd0);
    lookup(32'h304, 1'b0, 32'h0, "R8 rejected absent");
    lookup(32'h301, 1'b1, 32'h1234, "R5 queue overwrite");
    idle(1);
    expect_eq("R6 one drain count", 33'(entry_count), 33'd10);
    expect_eq("R6 one drain frees", 33'(q_full), 33'd0);
    idle(4);

    // masked delete
    issue(3'd4, {32'h0000_000F, 32'h0});
    issue(3'd1, {32'h300, 32'h0});
    expect_eq("R7 delete count", 33'(entry_count), 33'd6);
    issue(3'd4, 64'h0);
    lookup(32'h302, 1'b0, 32'h0, "R7 deleted gone");
    lookup(32'h101, 1'b1, 32'hA001, "R7 others kept");

    // almost-full
    issue(3'd5, 64'd8);
    expect_eq("R9 below point", 33'(a_full), 33'd0);
    issue(3'd6, 64'h0);
    ins(32'h400, 32'h4000);
    expect_eq("R9 at seven", 33'(a_full), 33'd0);
    ins(32'h401, 32'h4001);
    expect_eq("R9 at point", 33'(a_full), 33'd1);

    // table full in direct mode
    for (int i = 0; i < 8; i++) ins(32'h500 + i, 32'h5000 + i);
    expect_eq("R11 table full", 33'(t_full), 33'd1);
    expect_eq("R11 count sixteen", 33'(entry_count), 33'd16);
    ins(32'h508, 32'h5008);
    expect_eq("R8 table reject", 33'(ins_rej), 33'd1);
    expect_eq("R8 table count held", 33'(entry_count), 33'd16);
    lookup(32'h507, 1'b1, 32'h5007, "R3 last slot");

    // clear
    issue(3'd3, 64'h0);
    expect_eq("R10 clear count", 33'(entry_count), 33'd0);
    expect_eq("R10 clear flags", 33'({t_full, q_full, a_full}), 33'd0);
    lookup(32'h100, 1'b0, 32'h0, "R10 cleared miss");

    idle(3);
    expect_eq("R1 all lookups answered", 33'(sb_exp.size()), 33'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule